// File: doc/BRIEF.md
# Queued-Primitive I2C Bus Master

This block is an I2C master that runs no transfer sequence of its own. Software builds each transfer out of small bus primitives: start, stop, a single 0 or 1 bit, an 8-bit write, an 8-bit read and two kinds of acknowledge check. It writes these one at a time into a command register. Each write becomes one 16-bit entry in an eight-deep command queue. A bit-level engine pops the entries in order and plays each one onto open-drain SCL and SDA lines. The lines are driven through separate pull-low enables, and the SDA level is read back through an input pin.

A small register port gives access to four words: the command queue entry, a status word with sticky error flags, a one-byte read holding register and a clock control word. The SCL rate comes from an 8-bit prescaler and a 5-bit divider. Because the master never sends an acknowledge by itself, software ends each read byte with an explicit single-bit write: 0 for ACK, 1 for NACK. The SDA input passes through a synchronizer before the engine samples it.

Top module: `i2cq_master`

## Requirements
- R1: After reset the status word reads 0x0001, the clock control word reads 0x0012, and neither line is pulled low (scl_oe = 0, sda_oe = 0).
- R2: A command entry holds its opcode in bits [15:8] and its argument in bits [7:0]. Opcodes are 0x00 null, 0x10 one 0 bit, 0x11 one 1 bit, 0x12 byte write, 0x13 byte read, 0x14 stop, 0x15 start, 0x16 ACK check with flush, 0x17 ACK check without flush. Entries execute in the order they are written. Register addresses are 0 command, 1 status, 2 read data, 3 clock control.
- R3: Status bit 5 reads 1 while the queue holds 8 entries. A command write in that state is dropped and sets status bit 4.
- R4: Status bits 2 (bus error), 3 (read underflow) and 4 (queue overflow) stay set until software writes 1 to that bit at address 1.
- R5: Clock control bits [4:0] are the divider D and bits [12:5] are the prescaler P. One SCL period lasts 4*(P+1)*(D+2) clock cycles.
- R6: A start command takes one SCL period and ends with both lines pulled low. It pulls SDA low while SCL is high. A stop command takes one SCL period and ends with both lines released. It releases SDA while SCL is high.
- R7: A byte write sends bits [7:0] of the entry MSB first, one bit per SCL period. SDA changes only while SCL is low.
- R8: Commands 0x10 and 0x11 each send exactly one bit, of value 0 or 1.
- R9: A byte read samples SDA while SCL is high and assembles the 8 bits MSB first. When it completes, the byte appears at address 2 and status bit 1 is set. Reading address 2 clears bit 1.
- R10: Reading address 2 while status bit 1 is clear sets status bit 3.
- R11: Command 0x16 samples SDA during its single SCL pulse. A high level sets status bit 2 and discards every command still queued.
- R12: Command 0x17 also sets status bit 2 when it samples SDA high, but the commands queued behind it still execute.
- R13: Opcode 0x00, and any opcode not listed in R2, completes without moving either line. Status bit 0 reads 1 only when the queue is empty and no command is executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at address 2) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A stuck phase or bit counter shows on the wires within one SCL period. The bus monitor then counts the wrong number of SCL rises for a command, or sees a shifted byte. A queue pointer that slips shows up when the next command executes: wrong bits appear on the bus, or the full flag comes up at the wrong fill level right after the ninth write. Flag-handling faults, such as a flush that misses, a sticky bit that clears by itself or a lost read-ready, appear at the next status read, which the bench issues as soon as the engine reports idle.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

   localparam int OPC_W   = 8;
   localparam int ARG_W   = 8;
   localparam int ENTRY_W = OPC_W + ARG_W;

   localparam logic [7:0] OP_NULL    = 8'h00;
   localparam logic [7:0] OP_BIT0    = 8'h10;
   localparam logic [7:0] OP_BIT1    = 8'h11;
   localparam logic [7:0] OP_WBYTE   = 8'h12;
   localparam logic [7:0] OP_RBYTE   = 8'h13;
   localparam logic [7:0] OP_STOP    = 8'h14;
   localparam logic [7:0] OP_START   = 8'h15;
   localparam logic [7:0] OP_CHK     = 8'h16;
   localparam logic [7:0] OP_CHK_NF  = 8'h17;

   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_STAT = 2'd1;
   localparam logic [1:0] RA_RXD  = 2'd2;
   localparam logic [1:0] RA_CLK  = 2'd3;

   localparam int SB_IDLE = 0;
   localparam int SB_RDY  = 1;
   localparam int SB_ERR  = 2;
   localparam int SB_UFL  = 3;
   localparam int SB_OVF  = 4;
   localparam int SB_FULL = 5;

   // Line drive for one quarter of an SCL period: {scl_oe, sda_oe}
   function automatic logic [1:0] phase_drive(input logic [7:0] opc,
                                              input logic [1:0] ph,
                                              input logic       bitv);
      logic [1:0] r;
      if (opc == OP_START) begin
         case (ph)
            2'd0:    r = 2'b10;
            2'd1:    r = 2'b00;
            2'd2:    r = 2'b01;
            default: r = 2'b11;
         endcase
      end else if (opc == OP_STOP) begin
         case (ph)
            2'd0:    r = 2'b11;
            2'd1:    r = 2'b01;
            default: r = 2'b00;
         endcase
      end else begin
         r = {(ph == 2'd0) || (ph == 2'd3), !bitv};
      end
      return r;
   endfunction

endpackage

// File: rtl/i2cq_sync.sv
module i2cq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2cq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cq_cmd_fifo.sv
module i2cq_cmd_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   input  logic             flush,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2cq_cmd_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wptr, rptr;

   assign empty = (wptr == rptr);
   assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign dout  = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push && !full && !flush) mem[wptr[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push && !full) wptr <= wptr + 1'b1;
         if (pop && !empty) rptr <= rptr + 1'b1;
      end
   end
endmodule

// File: rtl/i2cq_qtick.sv
module i2cq_qtick #(
   parameter int PRE_W   = 8,
   parameter int DIV_W   = 5,
   parameter int DIV_OFS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   input  logic [DIV_W-1:0] div,
   output logic             qtick
);
   generate
      if (DIV_OFS < 1) begin : g_bad_ofs
         $error("i2cq_qtick: DIV_OFS must be at least 1");
      end
   endgenerate

   localparam logic [DIV_W:0] OFS_M1 = (DIV_W + 1)'(DIV_OFS - 1);

   logic [PRE_W-1:0] pcnt;
   logic [DIV_W:0]   dcnt;
   logic             pre_wrap, div_wrap;

   assign pre_wrap = (pcnt >= pre);
   assign div_wrap = (dcnt >= ({1'b0, div} + OFS_M1));
   assign qtick    = run && pre_wrap && div_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
         dcnt <= '0;
      end else if (!run) begin
         pcnt <= '0;
         dcnt <= '0;
      end else if (pre_wrap) begin
         pcnt <= '0;
         dcnt <= div_wrap ? '0 : dcnt + 1'b1;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
   import i2cq_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [ENTRY_W-1:0] cmd_entry,
   output logic               cmd_pop,
   input  logic               qtick,
   input  logic               sda_s,
   output logic               busy,
   output logic               data_op,
   output logic               scl_oe,
   output logic               sda_oe,
   output logic               rd_done,
   output logic [BYTE_W-1:0]  rd_byte,
   output logic               err_set,
   output logic               flush_req
);
   localparam int CW = $clog2(BYTE_W);

   generate
      if (BYTE_W != ARG_W) begin : g_bad_byte
         $error("i2cq_engine: BYTE_W must match the entry argument width");
      end
   endgenerate

   logic [7:0]        opc_in;
   logic [BYTE_W-1:0] arg_in;
   logic              known;
   logic              multi;
   logic              first_bit;

   logic [7:0]        op;
   logic [BYTE_W-1:0] shreg;
   logic [CW-1:0]     bitcnt;
   logic [1:0]        phase;
   logic              nack_l;
   logic              cur_bit;
   logic              is_chk;
   logic              done;

   assign opc_in = cmd_entry[ENTRY_W-1 -: OPC_W];
   assign arg_in = cmd_entry[BYTE_W-1:0];
   assign known  = (opc_in >= OP_BIT0) && (opc_in <= OP_CHK_NF);
   assign multi  = (opc_in == OP_WBYTE) || (opc_in == OP_RBYTE);

   always_comb begin
      if (opc_in == OP_BIT0)       first_bit = 1'b0;
      else if (opc_in == OP_WBYTE) first_bit = arg_in[BYTE_W-1];
      else                         first_bit = 1'b1;
   end

   always_comb begin
      if (op == OP_BIT0)       cur_bit = 1'b0;
      else if (op == OP_WBYTE) cur_bit = shreg[BYTE_W-1];
      else                     cur_bit = 1'b1;
   end

   assign is_chk  = (op == OP_CHK) || (op == OP_CHK_NF);
   assign data_op = (op == OP_BIT0) || (op == OP_BIT1) || (op == OP_WBYTE);
   assign cmd_pop = !busy && cmd_valid;
   assign done    = busy && qtick && (phase == 2'd3) && (bitcnt == '0);

   assign rd_done   = done && (op == OP_RBYTE);
   assign rd_byte   = shreg;
   assign err_set   = done && is_chk && nack_l;
   assign flush_req = done && (op == OP_CHK) && nack_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         op     <= OP_NULL;
         shreg  <= '0;
         bitcnt <= '0;
         phase  <= 2'd0;
         nack_l <= 1'b0;
         scl_oe <= 1'b0;
         sda_oe <= 1'b0;
      end else if (!busy) begin
         if (cmd_valid && known) begin
            busy   <= 1'b1;
            op     <= opc_in;
            shreg  <= arg_in;
            bitcnt <= multi ? CW'(BYTE_W - 1) : '0;
            phase  <= 2'd0;
            nack_l <= 1'b0;
            {scl_oe, sda_oe} <= phase_drive(opc_in, 2'd0, first_bit);
         end
      end else if (qtick) begin
         if (phase == 2'd3) begin
            if (bitcnt == '0) begin
               busy <= 1'b0;
            end else begin
               bitcnt <= bitcnt - 1'b1;
               phase  <= 2'd0;
               if (op == OP_WBYTE) begin
                  shreg <= {shreg[BYTE_W-2:0], 1'b0};
                  {scl_oe, sda_oe} <= phase_drive(op, 2'd0, shreg[BYTE_W-2]);
               end else begin
                  {scl_oe, sda_oe} <= phase_drive(op, 2'd0, 1'b1);
               end
            end
         end else begin
            phase <= phase + 2'd1;
            {scl_oe, sda_oe} <= phase_drive(op, phase + 2'd1, cur_bit);
            if (phase == 2'd2 && op == OP_RBYTE) shreg  <= {shreg[BYTE_W-2:0], sda_s};
            if (phase == 2'd2 && is_chk)         nack_l <= sda_s;
         end
      end
   end
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
   import i2cq_pkg::*;
#(
   parameter int         FIFO_DEPTH  = 8,
   parameter int         PRE_W       = 8,
   parameter int         DIV_W       = 5,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] DIV_RST     = 5'h12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_addr,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        scl_oe,
   output logic        sda_oe,
   input  logic        sda_in
);
   localparam int CLK_W = PRE_W + DIV_W;

   generate
      if (CLK_W > 16) begin : g_bad_clkw
         $error("i2cq_master: prescaler and divider must fit in 16 bits");
      end
      if (DIV_W != 5) begin : g_bad_divw
         $error("i2cq_master: divider field is 5 bits wide");
      end
   endgenerate

   logic [CLK_W-1:0]   clk_q;
   logic [ENTRY_W-1:0] fifo_dout;
   logic               fifo_empty, fifo_full;
   logic               cmd_pop;
   logic               eng_busy, eng_data_op;
   logic               qtick;
   logic               sda_s;
   logic               rd_done;
   logic [ARG_W-1:0]   rd_byte;
   logic               err_set, flush_req;
   logic [ARG_W-1:0]   rx_q;
   logic               rx_rdy;
   logic               flag_err, flag_ufl, flag_ovf;
   logic               cmd_wr, stat_wr, rxd_rd;
   logic [15:0]        status;

   assign cmd_wr  = reg_wr && (reg_addr == RA_CMD);
   assign stat_wr = reg_wr && (reg_addr == RA_STAT);
   assign rxd_rd  = reg_rd && (reg_addr == RA_RXD);

   i2cq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sda_in),
      .q    (sda_s)
   );

   i2cq_cmd_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (cmd_wr),
      .din  (reg_wdata),
      .pop  (cmd_pop),
      .flush(flush_req),
      .dout (fifo_dout),
      .empty(fifo_empty),
      .full (fifo_full)
   );

   i2cq_qtick #(.PRE_W(PRE_W), .DIV_W(DIV_W), .DIV_OFS(2)) u_qtick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (eng_busy),
      .pre  (clk_q[CLK_W-1:DIV_W]),
      .div  (clk_q[DIV_W-1:0]),
      .qtick(qtick)
   );

   i2cq_engine #(.BYTE_W(ARG_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(!fifo_empty),
      .cmd_entry(fifo_dout),
      .cmd_pop  (cmd_pop),
      .qtick    (qtick),
      .sda_s    (sda_s),
      .busy     (eng_busy),
      .data_op  (eng_data_op),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe),
      .rd_done  (rd_done),
      .rd_byte  (rd_byte),
      .err_set  (err_set),
      .flush_req(flush_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= CLK_W'(DIV_RST);
      end else if (reg_wr && reg_addr == RA_CLK) begin
         clk_q <= reg_wdata[CLK_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= '0;
         rx_rdy <= 1'b0;
      end else if (rd_done) begin
         rx_q   <= rd_byte;
         rx_rdy <= 1'b1;
      end else if (rxd_rd) begin
         rx_rdy <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_err <= 1'b0;
         flag_ufl <= 1'b0;
         flag_ovf <= 1'b0;
      end else begin
         if (err_set)                       flag_err <= 1'b1;
         else if (stat_wr && reg_wdata[SB_ERR]) flag_err <= 1'b0;
         if (rxd_rd && !rx_rdy)             flag_ufl <= 1'b1;
         else if (stat_wr && reg_wdata[SB_UFL]) flag_ufl <= 1'b0;
         if (cmd_wr && fifo_full)           flag_ovf <= 1'b1;
         else if (stat_wr && reg_wdata[SB_OVF]) flag_ovf <= 1'b0;
      end
   end

   always_comb begin
      status          = '0;
      status[SB_IDLE] = fifo_empty && !eng_busy;
      status[SB_RDY]  = rx_rdy;
      status[SB_ERR]  = flag_err;
      status[SB_UFL]  = flag_ufl;
      status[SB_OVF]  = flag_ovf;
      status[SB_FULL] = fifo_full;
   end

   always_comb begin
      case (reg_addr)
         RA_STAT: reg_rdata = status;
         RA_RXD:  reg_rdata = {{(16 - ARG_W){1'b0}}, rx_q};
         RA_CLK:  reg_rdata = {{(16 - CLK_W){1'b0}}, clk_q};
         default: reg_rdata = 16'h0000;
      endcase
   end
endmodule

// File: rtl/i2cq_master_chk.sv
module i2cq_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  reg_addr,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic [15:0] reg_wdata,
   input logic        scl_oe,
   input logic        sda_oe,
   input logic        eng_busy,
   input logic        eng_data_op,
   input logic        fifo_full,
   input logic        fifo_empty,
   input logic        flag_ovf,
   input logic        flag_err,
   input logic        flag_ufl,
   input logic        rx_rdy,
   input logic        flush_req
);
   p_drop_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && fifo_full) |=> flag_ovf);

   p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ovf && !(reg_wr && reg_addr == 2'd1 && reg_wdata[4])) |=> flag_ovf);

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_err && !(reg_wr && reg_addr == 2'd1 && reg_wdata[2])) |=> flag_err);

   p_sda_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && eng_data_op && !scl_oe) |-> $stable(sda_oe));

   p_rdy_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd2 && rx_rdy && !eng_busy) |=> !rx_rdy);

   p_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd2 && !rx_rdy) |=> flag_ufl);

   p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> (fifo_empty && flag_err && !eng_busy));
endmodule

bind i2cq_master i2cq_master_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_addr   (reg_addr),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_wdata  (reg_wdata),
   .scl_oe     (scl_oe),
   .sda_oe     (sda_oe),
   .eng_busy   (eng_busy),
   .eng_data_op(eng_data_op),
   .fifo_full  (fifo_full),
   .fifo_empty (fifo_empty),
   .flag_ovf   (flag_ovf),
   .flag_err   (flag_err),
   .flag_ufl   (flag_ufl),
   .rx_rdy     (rx_rdy),
   .flush_req  (flush_req)
);

// File: tb/sim_i2cq_master.sv
`timescale 1ns/1ps
module sim_i2cq_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        scl_oe, sda_oe;
   logic        sda_line, scl_line;

   // slave model and bus monitor state
   logic        slv_pull = 1'b0;
   logic [7:0]  slv_sh = 8'h0;
   int          slv_cnt = 0;
   logic [7:0]  arm_byte = 8'h0;
   int          arm_n = 0;
   int          arm_seq = 0;
   int          arm_seen = 0;
   logic        scl_prev = 1'b1, sda_prev = 1'b1;
   logic [15:0] mon_shift = 16'h0;
   int          mon_bits = 0, mon_starts = 0, mon_stops = 0;
   longint      cyc = 0, last_rise = 0, mon_period = 0;

   int checks = 0, fails = 0;
   bit done_flag = 1'b0;

   localparam longint WDOG = 150000;
   // {nack, data}: nack = 1 means no slave acknowledge
   localparam logic [8:0] VEC [0:5] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100, 9'h081, 9'h17E};

   assign sda_line = !(sda_oe || slv_pull);
   assign scl_line = !scl_oe;

   i2cq_master u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (arm_seq != arm_seen) begin
         arm_seen = arm_seq;
         slv_pull = !arm_byte[7];
         slv_sh   = {arm_byte[6:0], 1'b0};
         slv_cnt  = arm_n;
      end else if (scl_prev && !scl_line && slv_cnt > 0) begin
         slv_cnt = slv_cnt - 1;
         if (slv_cnt == 0) slv_pull = 1'b0;
         else begin
            slv_pull = !slv_sh[7];
            slv_sh   = {slv_sh[6:0], 1'b0};
         end
      end
      if (!scl_prev && scl_line) begin
         mon_shift  = {mon_shift[14:0], sda_line};
         mon_bits   = mon_bits + 1;
         mon_period = cyc - last_rise;
         last_rise  = cyc;
      end
      if (scl_prev && scl_line && sda_prev && !sda_line) mon_starts = mon_starts + 1;
      if (scl_prev && scl_line && !sda_prev && sda_line) mon_stops = mon_stops + 1;
      scl_prev = scl_line;
      sda_prev = sda_line;
   end

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc == WDOG) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog actual=%0d expected=<%0d cycles", cyc, WDOG);
         summary();
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic cmd(input logic [15:0] d);
      wr(2'd0, d);
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      for (int i = 0; i < 40000; i++) begin
         rd(2'd1, s);
         if (s[0]) break;
      end
   endtask

   task automatic arm(input logic [7:0] b, input int n);
      @(negedge clk);
      arm_byte = b; arm_n = n; arm_seq = arm_seq + 1;
      @(negedge clk);
   endtask

   initial begin
      logic [15:0] v;
      int b0, s0, p0;
      logic [1:0] lines;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd1, v); chk("R1 status", v, 16'h0001);
      rd(2'd3, v); chk("R1 clock word", v, 16'h0012);
      chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);

      wr(2'd3, 16'h0000);

      // R6 start
      s0 = mon_starts;
      cmd(16'h1500); wait_idle();
      chk("R6 start seen", mon_starts - s0, 1);
      chk("R6 lines after start", {scl_oe, sda_oe}, 2'b11);

      // R2 R7 R11 vector table: byte write followed by ACK check
      for (int i = 0; i < 6; i++) begin
         b0 = mon_bits;
         cmd({8'h12, VEC[i][7:0]}); wait_idle();
         chk("R7 byte on bus", mon_shift[7:0], VEC[i][7:0]);
         chk("R2 bit count", mon_bits - b0, 8);
         if (!VEC[i][8]) arm(8'h00, 1);
         cmd(16'h1600); wait_idle();
         rd(2'd1, v);
         chk("R11 error flag vs ack", v[2], VEC[i][8]);
         wr(2'd1, 16'h0004);
      end

      // R8 single bits
      b0 = mon_bits;
      cmd(16'h1000); cmd(16'h1100); wait_idle();
      chk("R8 two bits", mon_bits - b0, 2);
      chk("R8 bit values", mon_shift[1:0], 2'b01);

      // R13 null and unknown opcodes
      b0 = mon_bits; s0 = mon_starts; p0 = mon_stops; lines = {scl_oe, sda_oe};
      cmd(16'h00FF); cmd(16'h2000); cmd(16'h0000); wait_idle();
      chk("R13 no bits", mon_bits - b0, 0);
      chk("R13 no start/stop", (mon_starts - s0) + (mon_stops - p0), 0);
      chk("R13 lines held", {scl_oe, sda_oe}, lines);
      rd(2'd1, v); chk("R13 idle status", v, 16'h0001);

      // R9 byte read
      arm(8'hC3, 8);
      cmd(16'h1300); wait_idle();
      rd(2'd1, v); chk("R9 ready set", v[1], 1'b1);
      rd(2'd2, v); chk("R9 read byte", v, 16'h00C3);
      rd(2'd1, v); chk("R9 ready cleared", v[3:1], 3'b000);

      // R10 underflow, R4 clear
      rd(2'd2, v);
      rd(2'd1, v); chk("R10 underflow set", v[3], 1'b1);
      rd(2'd1, v); chk("R4 underflow sticky", v[3], 1'b1);
      wr(2'd1, 16'h0008);
      rd(2'd1, v); chk("R4 underflow cleared", v[3], 1'b0);

      // R12 check without flush
      b0 = mon_bits;
      cmd(16'h1700); cmd(16'h1296); wait_idle();
      rd(2'd1, v); chk("R12 error set", v[2], 1'b1);
      chk("R12 queue kept", mon_bits - b0, 9);
      chk("R12 byte after check", mon_shift[7:0], 8'h96);
      wr(2'd1, 16'h0004);

      // R11 flush on NACK
      b0 = mon_bits;
      cmd(16'h1600); cmd(16'h12A5); cmd(16'h125A); wait_idle();
      rd(2'd1, v); chk("R11 error set", v[2], 1'b1);
      chk("R11 queue discarded", mon_bits - b0, 1);
      wr(2'd1, 16'h0004);
      rd(2'd1, v); chk("R4 error cleared", v, 16'h0001);

      // R5 timing
      wr(2'd3, 16'h0003);
      cmd(16'h1255); wait_idle();
      chk("R5 period D=3 P=0", mon_period, 20);
      wr(2'd3, 16'h0021);
      cmd(16'h12AA); wait_idle();
      chk("R5 period D=1 P=1", mon_period, 24);

      // R3 overflow
      wr(2'd3, 16'h01FF);
      b0 = mon_bits;
      for (int i = 0; i < 9; i++) cmd(16'h1100);
      rd(2'd1, v);
      chk("R3 full flag", v[5], 1'b1);
      chk("R3 no overflow yet", v[4], 1'b0);
      cmd(16'h1100);
      rd(2'd1, v); chk("R3 overflow set", v[4], 1'b1);
      wait_idle();
      chk("R3 dropped entry", mon_bits - b0, 9);
      rd(2'd1, v); chk("R4 overflow sticky", v[4], 1'b1);
      wr(2'd1, 16'h0010);
      rd(2'd1, v); chk("R4 overflow cleared", v, 16'h0001);

      // R6 stop
      wr(2'd3, 16'h0000);
      p0 = mon_stops;
      cmd(16'h1400); wait_idle();
      chk("R6 stop seen", mon_stops - p0, 1);
      chk("R6 lines after stop", {scl_oe, sda_oe}, 2'b00);

      summary();
   end
endmodule